// File: doc/BRIEF.md
# Serial Command Data Receiver

This block is the write-only serial entry port of a display controller. A host drives a serial clock and a data line, and a byte arrives one bit per rising serial-clock edge, most significant bit first. A separate select line tells whether the byte is a command or display data. When the eighth bit has arrived, the block hands a parallel byte and its flag to the register and display-memory logic inside the chip. It marks the hand-over with a strobe that lasts one system-clock cycle.

All serial inputs pass through a two-flop synchronizer into the system clock domain. The rising serial-clock edge is then detected there. The port listens only while the active-low select is low and the active-high select is high. Any other select combination clears the partial byte and the bit count. A byte cut short by a deselect is therefore lost and produces no strobe.

Top module: `scdr_rx`

## Requirements
- R1: While and right after the synchronous active-high reset `rst` is held, `byte_valid` is 0, `byte_data` is 0x00 and `byte_is_data` is 0.
- R2: Bits are assembled most significant first: the first rising serial-clock edge of a byte supplies `byte_data[7]` and the eighth supplies `byte_data[0]`.
- R3: Eight rising serial-clock edges while enabled produce exactly one `byte_valid` pulse, and that pulse is exactly one system-clock cycle wide.
- R4: The bit count wraps after the eighth edge, so the next edge starts a new byte that does not depend on the previous one. Back-to-back bytes each produce their own pulse.
- R5: `byte_is_data` takes the value `ser_dc` had on the eighth (last) edge: 0 = command, 1 = display data. The value of `ser_dc` on the earlier seven edges has no effect.
- R6: The port is enabled only when `chip_sel_n`=0 and `chip_sel`=1. Under every other combination, serial-clock edges produce no pulse and leave `byte_data` unchanged.
- R7: Leaving the enabled state in the middle of a byte discards the partial byte and the bit count. The first byte after re-selection is assembled from its own eight bits only.
- R8: Asserting `rst` in the middle of a byte discards the partial byte and the count.
- R9: `byte_data` and `byte_is_data` hold their values between pulses, whatever `ser_dat` and `ser_dc` do.
- R10: `ser_dat` is taken at the rising serial-clock edge. A change of `ser_dat` while the serial clock stays high does not alter the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Active-low select |
| chip_sel | input | 1 | Active-high select |
| ser_clk | input | 1 | Serial clock (asynchronous to clk) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_dc | input | 1 | Command (0) / display data (1) select |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Last completed byte |
| byte_is_data | output | 1 | Flag of the last completed byte |

## Verification
The bench aims at bit order and at the flag being taken only on the last edge. A design that reverses the shift would return mirrored bytes. One that latches the flag early would mislabel bytes whose select changes on bit 0. The bench also deselects or resets the port after a few bits, and tries each of the three disabling select combinations. A design that keeps the partial count would report a shifted byte or a stray pulse. It also changes the data while the serial clock is high, which catches a design that samples by level instead of on the edge.

// File: rtl/scdr_pkg.sv
package scdr_pkg;

  // Next bit index, wrapping at the byte width.
  function automatic int unsigned scdr_next_count(input int unsigned cnt,
                                                  input int unsigned width);
    return (cnt + 1 >= width) ? 0 : cnt + 1;
  endfunction

  // Shift one bit in at the bottom, older bits move toward the MSB.
  function automatic logic [7:0] scdr_shift8(input logic [7:0] cur,
                                             input logic bit_in);
    return {cur[6:0], bit_in};
  endfunction

endpackage

// File: rtl/scdr_sync.sv
module scdr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= '0;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/scdr_edge.sv
module scdr_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/scdr_shifter.sv
module scdr_shifter
  import scdr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rise,
  input  logic              bit_in,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] shreg,
  output logic [DATA_W-1:0] byte_next,
  output logic              byte_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  always_comb begin
    if (DATA_W == 8) byte_next = DATA_W'(scdr_shift8(8'(sh_q), bit_in));
    else             byte_next = {sh_q[DATA_W-2:0], bit_in};
  end

  assign byte_done = enable & rise & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (rise) begin
      cnt_q <= CNT_W'(scdr_next_count(int'(cnt_q), DATA_W));
      sh_q  <= byte_done ? '0 : byte_next;
    end
  end

  assign bit_cnt = cnt_q;
  assign shreg   = sh_q;
endmodule

// File: rtl/scdr_rx.sv
module scdr_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              chip_sel,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_dc,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_is_data
);
  // Synchronized input vector: {sel_n, sel, sclk, dat, dc}
  logic [4:0] raw_in, sync_in;
  logic       sel_n_s, sel_s, sclk_s, dat_s, dc_s;

  assign raw_in = {chip_sel_n, chip_sel, ser_clk, ser_dat, ser_dc};

  scdr_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (sync_in)
  );

  assign {sel_n_s, sel_s, sclk_s, dat_s, dc_s} = sync_in;

  // Named internal events for the checker.
  logic              port_en;
  logic              sclk_rise;
  logic              byte_done;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] byte_next;

  assign port_en = ~sel_n_s & sel_s;

  scdr_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sclk_s),
    .rise  (sclk_rise)
  );

  scdr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .enable    (port_en),
    .rise      (sclk_rise),
    .bit_in    (dat_s),
    .bit_cnt   (bit_cnt),
    .shreg     (shreg),
    .byte_next (byte_next),
    .byte_done (byte_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_valid   <= 1'b0;
      byte_data    <= '0;
      byte_is_data <= 1'b0;
    end else begin
      byte_valid <= byte_done;
      if (byte_done) begin
        byte_data    <= byte_next;
        byte_is_data <= dc_s;
      end
    end
  end
endmodule

// File: rtl/scdr_rx_chk.sv
module scdr_rx_chk
  import scdr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              port_en,
  input logic              sclk_rise,
  input logic              byte_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] shreg,
  input logic              byte_valid,
  input logic [DATA_W-1:0] byte_data,
  input logic              byte_is_data
);
  // R3: strobe is one cycle wide
  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R3: a strobe always follows a completed byte
  a_r3_valid_after_done: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(byte_done));

  // R4: each enabled edge advances the count with wrap
  a_r4_count_advance: assert property (@(posedge clk) disable iff (rst)
    (port_en && sclk_rise) |=>
      (int'(bit_cnt) == scdr_next_count(int'($past(bit_cnt)), DATA_W)));

  // R6 / R7: a disabled port holds no partial state
  a_r7_deselect_clears: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (bit_cnt == '0 && shreg == '0));

  // R6: no strobe unless the port was enabled
  a_r6_valid_needs_enable: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(port_en));

  // R8: reset clears count and strobe
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (bit_cnt == '0 && !byte_valid));

  // R9: outputs are stable between strobes
  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |-> ($stable(byte_data) && $stable(byte_is_data)));
endmodule

bind scdr_rx scdr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .port_en      (port_en),
  .sclk_rise    (sclk_rise),
  .byte_done    (byte_done),
  .bit_cnt      (bit_cnt),
  .shreg        (shreg),
  .byte_valid   (byte_valid),
  .byte_data    (byte_data),
  .byte_is_data (byte_is_data)
);

// File: tb/tb_scdr_rx.sv
`timescale 1ns/1ps
module tb_scdr_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_sel_n = 1'b1;
  logic       chip_sel = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_dc = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_is_data;

  always #10 clk = ~clk; // 50 MHz

  scdr_rx dut (
    .clk          (clk),
    .rst          (rst),
    .chip_sel_n   (chip_sel_n),
    .chip_sel     (chip_sel),
    .ser_clk      (ser_clk),
    .ser_dat      (ser_dat),
    .ser_dc       (ser_dc),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .byte_is_data (byte_is_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Strobe monitor: records each pulse and checks its width.
  int         n_pulse = 0;
  logic [7:0] rec_b [16];
  logic       rec_f [16];
  logic       prev_valid = 1'b0;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (n_pulse < 16) begin
        rec_b[n_pulse] = byte_data;
        rec_f[n_pulse] = byte_is_data;
      end
      n_pulse++;
    end
    if (byte_valid && prev_valid) begin
      n_checks++; n_fail++;
      $display("FAIL R3: strobe wider than one cycle (actual 2+, expected 1)");
    end
    prev_valid = byte_valid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic select(input logic n, input logic p);
    @(negedge clk);
    chip_sel_n = n;
    chip_sel   = p;
    wait_cyc(6);
  endtask

  task automatic send_bit(input logic b, input logic dc);
    @(negedge clk);
    ser_dat = b;
    ser_dc  = dc;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic dc);
    for (int i = 7; i >= 0; i--) send_bit(v[i], dc);
  endtask

  task automatic settle();
    wait_cyc(8);
  endtask

  // R1
  task automatic t_reset();
    check("R1 valid", byte_valid, 0);
    check("R1 data", byte_data, 8'h00);
    check("R1 flag", byte_is_data, 0);
  endtask

  // R2 R3 R5
  task automatic t_single();
    n_pulse = 0;
    send_byte(8'hA5, 1'b1); settle();
    check("R3 one pulse", n_pulse, 1);
    check("R2 byte A5", rec_b[0], 8'hA5);
    check("R5 data flag", rec_f[0], 1);
    n_pulse = 0;
    send_byte(8'h3C, 1'b0); settle();
    check("R3 one pulse cmd", n_pulse, 1);
    check("R2 byte 3C", rec_b[0], 8'h3C);
    check("R5 command flag", rec_f[0], 0);
  endtask

  // R5: only the last bit's select counts
  task automatic t_flag_last();
    n_pulse = 0;
    for (int i = 7; i >= 1; i--) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1);
    for (int i = 7; i >= 1; i--) send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b0);
    settle();
    check("R5 pulses", n_pulse, 2);
    check("R5 late high flag", rec_f[0], 1);
    check("R5 late high byte", rec_b[0], 8'hFE);
    check("R5 late low flag", rec_f[1], 0);
    check("R5 late low byte", rec_b[1], 8'h01);
  endtask

  // R4
  task automatic t_back_to_back();
    logic [7:0] v [4] = '{8'h01, 8'h80, 8'hFF, 8'h00};
    n_pulse = 0;
    for (int k = 0; k < 4; k++) send_byte(v[k], k[0]);
    settle();
    check("R4 pulse count", n_pulse, 4);
    for (int k = 0; k < 4; k++) begin
      check("R4 byte", rec_b[k], v[k]);
      check("R4 flag", rec_f[k], k[0]);
    end
  endtask

  // R7
  task automatic t_deselect_mid();
    n_pulse = 0;
    send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1);
    select(1'b1, 1'b1);
    select(1'b0, 1'b1);
    send_byte(8'h5A, 1'b1); settle();
    check("R7 single pulse", n_pulse, 1);
    check("R7 fresh byte", rec_b[0], 8'h5A);
    n_pulse = 0;
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
    select(1'b0, 1'b0);
    select(1'b0, 1'b1);
    send_byte(8'hC6, 1'b0); settle();
    check("R7 single pulse 2", n_pulse, 1);
    check("R7 fresh byte 2", rec_b[0], 8'hC6);
  endtask

  // R6 R9
  task automatic t_disabled();
    logic [7:0] held;
    logic hf;
    held = byte_data; hf = byte_is_data;
    for (int c = 0; c < 3; c++) begin
      n_pulse = 0;
      case (c)
        0: select(1'b1, 1'b1);
        1: select(1'b0, 1'b0);
        default: select(1'b1, 1'b0);
      endcase
      send_byte(8'h99, ~hf); settle();
      check("R6 no pulse when disabled", n_pulse, 0);
      check("R6 data unchanged", byte_data, held);
      check("R9 flag unchanged", byte_is_data, hf);
    end
    select(1'b0, 1'b1);
    n_pulse = 0;
    send_byte(8'h42, 1'b1); settle();
    check("R6 enabled again", rec_b[0], 8'h42);
  endtask

  // R8
  task automatic t_reset_mid();
    n_pulse = 0;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
    @(negedge clk); rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(4);
    send_byte(8'hC3, 1'b1); settle();
    check("R8 one pulse", n_pulse, 1);
    check("R8 fresh byte", rec_b[0], 8'hC3);
  endtask

  // R10
  task automatic t_rise_sample();
    logic [7:0] v = 8'h96;
    n_pulse = 0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      ser_dat = v[i]; ser_dc = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_dat = ~v[i]; ser_dc = 1'b0;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    settle();
    check("R10 pulse", n_pulse, 1);
    check("R10 edge-sampled byte", rec_b[0], v);
    check("R10 edge-sampled flag", rec_f[0], 1);
  endtask

  // R9
  task automatic t_hold();
    logic [7:0] held = byte_data;
    logic hf = byte_is_data;
    n_pulse = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ser_dat = ~ser_dat; ser_dc = ~ser_dc;
    end
    settle();
    check("R9 no pulse without clock", n_pulse, 0);
    check("R9 data held", byte_data, held);
    check("R9 flag held", byte_is_data, hf);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    select(1'b0, 1'b1);
    t_single();
    t_flag_last();
    t_back_to_back();
    t_deselect_mid();
    t_disabled();
    t_reset_mid();
    t_rise_sample();
    t_hold();
    finish_run();
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end (actual timeout, expected completion)");
    finish_run();
  end
endmodule